// File: doc/BRIEF.md
# Receive Buffer Descriptor Engine

This block stores incoming frames in memory through a ring of 8-byte buffer descriptors. Each descriptor names a buffer in memory, and the engine fills it one byte at a time from a valid/last byte stream. A frame is spread over as many descriptors as it needs, and each descriptor takes no more than a programmable maximum number of bytes. When a descriptor is finished, the engine writes back its byte count and status flags and raises a one-cycle event: a buffer event for a descriptor in the middle of a frame, a frame event for the last one.

Software fills the ring, places the ring's base address on `ring_base`, raises `enable` and pulses `kick` to start reception. The engine then reads the current descriptor. If that descriptor is not marked empty, it drops out of the active state and reception stalls until the next kick. Frames that arrive while the engine is inactive are consumed and thrown away. The descriptor pointer survives from one frame to the next. It moves forward by eight bytes, or returns to the ring base after a descriptor that carries the wrap flag. CRC checking and address filtering are not part of this block.

Top module: `rxbd_engine`

## Requirements
- R1: Descriptor word 0 (byte address ptr) holds the length in bits 15:0 and the flags in bits 31:16: empty at word bit 31, wrap at bit 29, last at bit 27, length violation at bit 21. Word 1 holds the buffer byte address. Write-back puts the stored byte count in the length field, clears empty, keeps wrap, and leaves every other flag bit as it was read, except last and length violation.
- R2: A descriptor receives at most `max_buf` bytes (`max_buf` ≥ 1). Frame byte k of a descriptor goes to byte address buffer+k, on lane (address mod 4) of word address/4, with only that lane enabled.
- R3: After write-back, the pointer advances by 8, or reloads from `ring_base` (low three bits cleared) when the descriptor's wrap flag is set.
- R4: The last descriptor of a frame gets the last flag and pulses `ev_rxf` for one cycle. Every other filled descriptor has last clear and pulses `ev_rxb` instead.
- R5: The length violation flag is set in a frame's last descriptor exactly when the frame's total byte count exceeds `frame_limit`. The frame is still stored in full.
- R6: While `rx_active` is low, `in_ready` is high, and accepted bytes are discarded without any memory access or event.
- R7: `kick` while enabled and inactive sets `rx_active` and reads the current descriptor. If that descriptor's empty flag is clear, `rx_active` returns low and nothing is written.
- R8: The descriptor pointer is kept from one frame to the next. A following frame starts in the descriptor after the one that ended the previous frame.
- R9: If the next descriptor is not empty partway through a frame, the remaining bytes of that frame are discarded, `rx_active` goes low, and no frame event is raised for that frame.
- R10: With `enable` low, `rx_active` is low one cycle later, the pointer reloads from `ring_base`, and `kick` is ignored.
- R11: `in_ready` is low while a descriptor is being fetched or written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; low resets pointer and activity |
| kick | input | 1 | Request to activate reception |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| max_buf | input | 16 | Maximum bytes stored per descriptor |
| frame_limit | input | 16 | Frame length above which the violation flag is set |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_active | output | 1 | Receive-activate state |
| ev_rxb | output | 1 | One-cycle pulse: a mid-frame descriptor was filled |
| ev_rxf | output | 1 | One-cycle pulse: a frame's last descriptor was written |

## Verification
Some properties are checked on every cycle. Memory stays idle whenever the engine is inactive. Activation always traces back to a kick, and a low enable always leaves the engine inactive. Every event follows a write-back, and no descriptor ever holds more than `max_buf` bytes. Other behaviour only shows up in the stored memory contents, and the bench's scenarios cover it: the exact write-back words, where the bytes land, the return to the ring base on wrap, the length violation at and just past the limit, a ring that is full at kick time, a ring that fills partway through a frame, and the pointer reload when the engine is disabled.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
    localparam int LEN_W      = 16;
    localparam int FLAG_W     = 16;
    localparam int DESC_BYTES = 8;
    localparam int FL_EMPTY   = 15;
    localparam int FL_WRAP    = 13;
    localparam int FL_LAST    = 11;
    localparam int FL_LONG    = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_ADR  = 3'd2,
        ST_LOAD = 3'd3,
        ST_DATA = 3'd4,
        ST_WB   = 3'd5
    } rx_st_e;
endpackage

// File: rtl/rxbd_lane.sv
module rxbd_lane #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]        bufa,
    input  logic [rxbd_pkg::LEN_W-1:0] offs,
    input  logic [7:0]               data,
    output logic [ADDR_W-3:0]        waddr,
    output logic [3:0]               be,
    output logic [31:0]              wdata
);
    logic [ADDR_W-1:0] byte_addr;

    always_comb begin
        byte_addr = bufa + ADDR_W'(offs);
        waddr     = byte_addr[ADDR_W-1:2];
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        always_comb begin
            be[g]            = (byte_addr[1:0] == 2'(g));
            wdata[8*g +: 8]  = data;
        end
    end
endmodule

// File: rtl/rxbd_status.sv
module rxbd_status (
    input  logic [rxbd_pkg::FLAG_W-1:0] flags_in,
    input  logic                        is_last,
    input  logic                        too_long,
    input  logic [rxbd_pkg::LEN_W-1:0]  count,
    output logic [31:0]                 word
);
    import rxbd_pkg::*;
    logic [FLAG_W-1:0] f;

    always_comb begin
        f           = flags_in;
        f[FL_EMPTY] = 1'b0;
        f[FL_LAST]  = is_last;
        f[FL_LONG]  = too_long;
        word        = {f, count};
    end
endmodule

// File: rtl/rxbd_next_ptr.sv
module rxbd_next_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] base_al,
    input  logic              wrap,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(rxbd_pkg::DESC_BYTES);

    always_comb begin
        nxt = wrap ? base_al : cur + STEP;
    end
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine #(
    parameter int ADDR_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        kick,
    input  logic [ADDR_W-1:0]           ring_base,
    input  logic [rxbd_pkg::LEN_W-1:0]  max_buf,
    input  logic [rxbd_pkg::LEN_W-1:0]  frame_limit,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    input  logic                        in_last,
    output logic                        in_ready,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-3:0]           mem_addr,
    output logic [3:0]                  mem_be,
    output logic [31:0]                 mem_wdata,
    input  logic [31:0]                 mem_rdata,
    output logic                        rx_active,
    output logic                        ev_rxb,
    output logic                        ev_rxf
);
    import rxbd_pkg::*;

    localparam int WA_W = ADDR_W - 2;

    typedef struct packed {
        rx_st_e             st;
        logic               active;
        logic [ADDR_W-1:0]  ptr;
        logic [ADDR_W-1:0]  bufa;
        logic [LEN_W-1:0]   cnt;
        logic [LEN_W-1:0]   total;
        logic [FLAG_W-1:0]  flags;
        logic               open;
        logic               skip;
        logic               wb_last;
        logic               wb_long;
        logic               ev_b;
        logic               ev_f;
    } rx_state_t;

    rx_state_t r_q, r_d;

    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] ptr_nx;
    logic [WA_W-1:0]   lane_addr;
    logic [3:0]        lane_be;
    logic [31:0]       lane_data;
    logic [31:0]       wb_word;
    logic              acc;
    logic [LEN_W-1:0]  cnt_nx;
    logic [LEN_W-1:0]  total_nx;

    assign base_al = {ring_base[ADDR_W-1:3], 3'b000};

    rxbd_lane #(.ADDR_W(ADDR_W)) u_lane (
        .bufa  (r_q.bufa),
        .offs  (r_q.cnt),
        .data  (in_data),
        .waddr (lane_addr),
        .be    (lane_be),
        .wdata (lane_data)
    );

    rxbd_status u_status (
        .flags_in (r_q.flags),
        .is_last  (r_q.wb_last),
        .too_long (r_q.wb_long),
        .count    (r_q.cnt),
        .word     (wb_word)
    );

    rxbd_next_ptr #(.ADDR_W(ADDR_W)) u_next (
        .cur     (r_q.ptr),
        .base_al (base_al),
        .wrap    (r_q.flags[FL_WRAP]),
        .nxt     (ptr_nx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.ev_b  = 1'b0;
        r_d.ev_f  = 1'b0;
        in_ready  = (r_q.st == ST_IDLE) || (r_q.st == ST_DATA);
        acc       = in_valid && in_ready;
        cnt_nx    = r_q.cnt + 1'b1;
        total_nx  = r_q.total + 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.ptr[ADDR_W-1:2];
        mem_be    = 4'h0;
        mem_wdata = 32'h0;

        if (!enable) begin
            r_d.st     = ST_IDLE;
            r_d.active = 1'b0;
            r_d.ptr    = base_al;
            r_d.total  = '0;
            r_d.open   = 1'b0;
            r_d.skip   = acc ? !in_last : (r_q.skip | r_q.open);
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (acc) r_d.skip = !in_last;
                    if (kick) begin
                        r_d.active = 1'b1;
                        r_d.st     = ST_HDR;
                    end
                end
                ST_HDR: begin
                    mem_req = 1'b1;
                    r_d.st  = ST_ADR;
                end
                ST_ADR: begin
                    r_d.flags = mem_rdata[31:16];
                    if (!mem_rdata[16+FL_EMPTY]) begin
                        r_d.active = 1'b0;
                        r_d.st     = ST_IDLE;
                        r_d.skip   = r_q.skip | r_q.open;
                        r_d.open   = 1'b0;
                        r_d.total  = '0;
                    end else begin
                        mem_req  = 1'b1;
                        mem_addr = r_q.ptr[ADDR_W-1:2] + 1'b1;
                        r_d.st   = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    r_d.bufa = mem_rdata[ADDR_W-1:0];
                    r_d.cnt  = '0;
                    r_d.st   = ST_DATA;
                end
                ST_DATA: begin
                    if (acc) begin
                        if (r_q.skip) begin
                            r_d.skip = !in_last;
                        end else begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = lane_addr;
                            mem_be    = lane_be;
                            mem_wdata = lane_data;
                            r_d.cnt   = cnt_nx;
                            r_d.total = total_nx;
                            r_d.open  = !in_last;
                            if (in_last || cnt_nx == max_buf) begin
                                r_d.st      = ST_WB;
                                r_d.wb_last = in_last;
                                r_d.wb_long = in_last &&
                                    ({1'b0, total_nx} > {1'b0, frame_limit});
                            end
                        end
                    end
                end
                ST_WB: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_be    = 4'hF;
                    mem_wdata = wb_word;
                    r_d.ev_f  = r_q.wb_last;
                    r_d.ev_b  = !r_q.wb_last;
                    r_d.ptr   = ptr_nx;
                    if (r_q.wb_last) r_d.total = '0;
                    r_d.st    = ST_HDR;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_active = r_q.active;
    assign ev_rxb    = r_q.ev_b;
    assign ev_rxf    = r_q.ev_f;

    // R6
    inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |-> !mem_req);

    // R7
    kick_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> $past(kick && enable));

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rx_active);

    // R4
    event_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rxb || ev_rxf) |-> $past(r_q.st == ST_WB));

    // R2
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA) |-> (r_q.cnt < max_buf));
endmodule

// File: tb/sim_rxbd_engine.sv
module sim_rxbd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int RING       = 16'h100;
    localparam int BUFS       = 16'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        kick = 1'b0;
    logic [15:0] ring_base = 16'(RING);
    logic [15:0] max_buf = 16'd16;
    logic [15:0] frame_limit = 16'd100;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        rx_active, ev_rxb, ev_rxf;

    logic [31:0] mem [256];
    int n_chk = 0, n_bad = 0, n_rxb = 0, n_rxf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxbd_engine #(.ADDR_W(ADDR_W)) u0 (
        .clk, .rst_n, .enable, .kick, .ring_base, .max_buf, .frame_limit,
        .in_valid, .in_data, .in_last, .in_ready,
        .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
        .rx_active, .ev_rxb, .ev_rxf
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
            end
        end
        if (rst_n && ev_rxb) n_rxb++;
        if (rst_n && ev_rxf) n_rxf++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dw0(input int i);
        return mem[(RING >> 2) + 2*i];
    endfunction

    function automatic logic [7:0] rbyte(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    task automatic setup(input int n, input int mb, input int lim);
        @(negedge clk);
        enable = 1'b0;
        max_buf = 16'(mb);
        frame_limit = 16'(lim);
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < n; i++) begin
            mem[(RING >> 2) + 2*i]     = 32'h8000_0000 | ((i == n-1) ? 32'h2000_0000 : 32'h0);
            mem[(RING >> 2) + 2*i + 1] = 32'(BUFS + i*16'h40);
        end
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_kick(output logic rdy_after);
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        rdy_after = in_ready;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(seed + i);
            in_last  = (i == len-1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R6 reset rx_active", 32'(rx_active), 0);
        chk("R6 reset mem_req", 32'(mem_req), 0);
        chk("R4 reset events", 32'({ev_rxb, ev_rxf}), 0);
    endtask

    task automatic t_single;
        int b0, f0; logic rdy;
        setup(4, 16, 100);
        do_kick(rdy);
        chk("R11 in_ready low during fetch", 32'(rdy), 0);
        chk("R7 active after kick", 32'(rx_active), 1);
        b0 = n_rxb; f0 = n_rxf;
        send(10, 8'h10);
        chk("R1 single word0", dw0(0), 32'h0800_000A);
        chk("R1 buffer word kept", mem[(RING >> 2) + 1], 32'(BUFS));
        chk("R2 first byte", 32'(rbyte(BUFS)), 32'h10);
        chk("R2 last byte", 32'(rbyte(BUFS + 9)), 32'h19);
        chk("R4 single rxf", 32'(n_rxf - f0), 1);
        chk("R4 single rxb", 32'(n_rxb - b0), 0);
        chk("R8 still active", 32'(rx_active), 1);
    endtask

    task automatic t_split;
        int b0, f0; logic rdy;
        setup(4, 8, 100);
        do_kick(rdy);
        b0 = n_rxb; f0 = n_rxf;
        send(20, 8'h40);
        chk("R2 split d0", dw0(0), 32'h0000_0008);
        chk("R2 split d1", dw0(1), 32'h0000_0008);
        chk("R4 split d2", dw0(2), 32'h0800_0004);
        chk("R2 split byte d1", 32'(rbyte(BUFS + 16'h40)), 32'h48);
        chk("R2 split byte d2", 32'(rbyte(BUFS + 16'h80 + 3)), 32'h53);
        chk("R4 split rxb", 32'(n_rxb - b0), 2);
        chk("R4 split rxf", 32'(n_rxf - f0), 1);
        send(3, 8'h70);
        chk("R8 next frame d3", dw0(3), 32'h2800_0003);
        chk("R8 next frame byte", 32'(rbyte(BUFS + 16'hC0)), 32'h70);
        chk("R7 wrap to used desc stalls", 32'(rx_active), 0);
    endtask

    task automatic t_wrap;
        logic rdy;
        setup(2, 16, 100);
        mem[(RING >> 2) + 4] = 32'h8000_0000;
        mem[(RING >> 2) + 5] = 32'h0000_0300;
        do_kick(rdy);
        send(4, 8'h01);
        send(4, 8'h21);
        chk("R3 wrap d1", dw0(1), 32'h2800_0004);
        chk("R3 ring full after wrap", 32'(rx_active), 0);
        mem[RING >> 2] = 32'h8000_0000;
        do_kick(rdy);
        send(5, 8'h90);
        chk("R3 base reused", dw0(0), 32'h0800_0005);
        chk("R3 base buffer byte", 32'(rbyte(BUFS)), 32'h90);
        chk("R3 past-end untouched", dw0(2), 32'h8000_0000);
    endtask

    task automatic t_limit;
        logic rdy;
        setup(4, 16, 12);
        do_kick(rdy);
        send(13, 8'h30);
        chk("R5 over limit", dw0(0), 32'h0820_000D);
        send(12, 8'h50);
        chk("R5 at limit", dw0(1), 32'h0800_000C);
    endtask

    task automatic t_inactive;
        int f0; logic rdy;
        setup(4, 16, 100);
        f0 = n_rxf;
        send(6, 8'hA0);
        chk("R6 dropped desc", dw0(0), 32'h8000_0000);
        chk("R6 dropped byte", 32'(rbyte(BUFS)), 0);
        chk("R6 no event", 32'(n_rxf - f0), 0);
        do_kick(rdy);
        send(4, 8'hB0);
        chk("R6 stored after kick", dw0(0), 32'h0800_0004);
        chk("R6 first byte after kick", 32'(rbyte(BUFS)), 32'hB0);
    endtask

    task automatic t_full_kick;
        int f0; logic rdy;
        setup(2, 16, 100);
        mem[RING >> 2] = 32'h0;
        do_kick(rdy);
        chk("R7 full at kick", 32'(rx_active), 0);
        f0 = n_rxf;
        send(3, 8'h11);
        chk("R7 desc untouched", dw0(0), 32'h0);
        chk("R7 no frame event", 32'(n_rxf - f0), 0);
    endtask

    task automatic t_full_mid;
        int b0, f0; logic rdy;
        setup(2, 4, 100);
        mem[(RING >> 2) + 2] = 32'h2000_0000;
        do_kick(rdy);
        b0 = n_rxb; f0 = n_rxf;
        send(10, 8'hC0);
        chk("R9 first desc", dw0(0), 32'h0000_0004);
        chk("R9 rxb", 32'(n_rxb - b0), 1);
        chk("R9 no rxf", 32'(n_rxf - f0), 0);
        chk("R9 inactive", 32'(rx_active), 0);
        chk("R9 full desc untouched", dw0(1), 32'h2000_0000);
        chk("R9 rest discarded", 32'(rbyte(BUFS + 16'h40)), 0);
        mem[(RING >> 2) + 2] = 32'hA000_0000;
        do_kick(rdy);
        send(2, 8'hD0);
        chk("R8 resumes at d1", dw0(1), 32'h2800_0002);
        chk("R9 new frame first byte", 32'(rbyte(BUFS + 16'h40)), 32'hD0);
    endtask

    task automatic t_disable;
        logic rdy;
        setup(4, 16, 100);
        do_kick(rdy);
        send(3, 8'h61);
        @(negedge clk);
        enable = 1'b0;
        kick = 1'b1;
        @(negedge clk);
        chk("R10 inactive when disabled", 32'(rx_active), 0);
        @(negedge clk);
        chk("R10 kick ignored", 32'(rx_active), 0);
        kick = 1'b0;
        mem[RING >> 2] = 32'h8000_0000;
        enable = 1'b1;
        do_kick(rdy);
        send(2, 8'hE0);
        chk("R10 pointer back at base", dw0(0), 32'h0800_0002);
        chk("R10 d1 untouched", dw0(1), 32'h8000_0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_single;
        t_split;
        t_wrap;
        t_limit;
        t_inactive;
        t_full_kick;
        t_full_mid;
        t_disable;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule